// File: doc/BRIEF.md
# Micro-op Cache Mode Controller

This block sits in the instruction front end. It decides whether instructions come from the instruction cache and decoders, or only from a micro-op cache. It watches every lookup made by a small, fast branch predictor.

Each lookup carries two pieces of information:
- a per-branch "built" flag, which says whether the target basic block is already known to be resident in the micro-op cache;
- a qualifier, which says whether the current code is predictable enough, and small enough, to be worth caching.

The controller runs in one of three modes:
- **Filter**: build nothing.
- **Build**: allocate unbuilt target blocks into the micro-op cache.
- **Fetch**: turn off the instruction cache, the decoders and (while the small predictor stays accurate) the main predictor.

Mode changes follow two saturating edge counters and a lookup timer. A counter of built edges and a counter of unbuilt edges are compared against programmable integer ratios by cross-multiplication, so no divider is needed. The timer counts lookups made in Build mode.

When the micro-op cache reports a tag hit, the controller writes back to the predictor to set that branch's built flag. This replaces a tag check at prediction time. A build request for the same block in that cycle is squashed.

Top module: `uop_mode_ctrl`

## Requirements
- R1: After reset, `mode` is Filter (mode encoding: 0 = Filter, 1 = Build, 2 = Fetch). `icacheEn`, `decodeEn` and `mainBpEn` are high, and `allocReq` is low.
- R2: In Filter mode, the mode becomes Build at the clock edge that ends a cycle with `lkValid` and `lkQualified` both high. A lookup without the qualifier leaves the mode in Filter.
- R3: `allocReq` is high in the same cycle as a lookup in Build mode whose `lkBuilt` is 0, and `allocIdx` equals `lkIdx`. A lookup whose `lkBuilt` is 1, and any lookup in Filter or Fetch mode, gives no `allocReq`.
- R4: A cycle with `tagValid` and `tagHit` both high raises `builtWrEn`, with `builtWrIdx` equal to `tagIdx`, in that same cycle. If `tagIdx` equals `lkIdx`, that cycle's `allocReq` is squashed.
- R5: In Build mode, the mode becomes Fetch once all of these hold on the counts so far:
  - fetch edges ≥ `cfgFetchRatio` × build edges;
  - fetch edges + build edges ≥ MIN_EDGES (default 4);
  - the lookup timer is below `cfgTimerLimit`.

  The mode changes one cycle after the counter update that meets the condition.
- R6: In Build mode, when the timer reaches `cfgTimerLimit` without the Fetch condition, the mode returns to Filter.
- R7: In Fetch mode, `icacheEn` and `decodeEn` are low, and `mainBpEn` is low until a misprediction is reported.
- R8: In Fetch mode, edges keep being counted. The mode returns to Filter once both of these hold:
  - build edges ≥ `cfgFilterRatio` × fetch edges;
  - the total edge count is at least MIN_EDGES.
- R9: A cycle in Fetch mode with `lkMispredict` high makes `mainBpEn` high from the next cycle until the mode changes.
- R10: The edge counters and the timer saturate at their maximum (255 for the default 8-bit edge counters) instead of wrapping.
- R11: All counters clear on every mode change, so counts from an earlier stay in a mode never carry into a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Small-predictor lookup valid |
| lkIdx | input | IDX_W | Predictor entry index of the lookup |
| lkBuilt | input | 1 | Built flag of the looked-up entry |
| lkQualified | input | 1 | Code is predictable and fits predictor and micro-op cache |
| lkMispredict | input | 1 | Small predictor reports a misprediction |
| tagValid | input | 1 | Micro-op cache tag response valid |
| tagHit | input | 1 | Tag response found the block resident |
| tagIdx | input | IDX_W | Predictor entry the tag response belongs to |
| cfgFetchRatio | input | THR_W | Fetch/build ratio for entering Fetch mode |
| cfgFilterRatio | input | THR_W | Build/fetch ratio for leaving Fetch mode |
| cfgTimerLimit | input | TIMER_W | Build-mode lookup budget |
| mode | output | 2 | Current mode |
| icacheEn | output | 1 | Instruction cache enable |
| decodeEn | output | 1 | Decoder enable |
| mainBpEn | output | 1 | Main branch predictor enable |
| allocReq | output | 1 | Allocate target block in micro-op cache |
| allocIdx | output | IDX_W | Entry index for the allocation |
| builtWrEn | output | 1 | Set built flag in predictor |
| builtWrIdx | output | IDX_W | Entry whose built flag is set |

## Verification
The Build-mode decision is driven by a table of sequences. Each sequence is a run of unbuilt lookups followed by a run of built lookups, under a given ratio and timer limit. The table separates three cases:
- the ratio met exactly, versus one edge short of it;
- a timeout that arrives before the ratio is met;
- the timer equal to the limit, versus one below it, with an otherwise passing ratio.

Directed sequences cover the rest:
- the squash of an allocation when a tag hit arrives for the same index, against a hit for a different index;
- a return to Filter from Fetch that is one edge short of the minimum count, and then met;
- a misprediction re-enabling the main predictor;
- 300 unbuilt edges, which tell a saturating counter from a wrapping one;
- a timeout followed by re-entry to Build, which shows whether the timer was cleared.

// File: rtl/uop_mode_pkg.sv
package uop_mode_pkg;

  typedef enum logic [1:0] {
    MODE_FILTER = 2'd0,
    MODE_BUILD  = 2'd1,
    MODE_FETCH  = 2'd2
  } uopMode_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clearAll;
    logic incBuild;
    logic incFetch;
    logic incTimer;
  } cntStrobe_t;

  // Decision flags from the datapath back to control
  typedef struct packed {
    logic fetchReady;
    logic filterReady;
    logic timeout;
  } cntFlags_t;

endpackage

// File: rtl/uop_sat_cnt.sv
module uop_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)                         cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (inc && (cnt != MAX_VAL))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uop_mode_cnt.sv
module uop_mode_cnt
  import uop_mode_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TIMER_W   = 10,
  parameter int THR_W     = 4,
  parameter int MIN_EDGES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strobe,
  input  logic [THR_W-1:0]   cfgFetchRatio,
  input  logic [THR_W-1:0]   cfgFilterRatio,
  input  logic [TIMER_W-1:0] cfgTimerLimit,
  output cntFlags_t          flags
);
  localparam int PROD_W = CNT_W + THR_W;
  localparam int SUM_W  = CNT_W + 1;
  localparam int NUM_EDGE_CNT = 2;

  logic [CNT_W-1:0]   edgeCnt [NUM_EDGE_CNT];
  logic [TIMER_W-1:0] timerCnt;
  logic [NUM_EDGE_CNT-1:0] edgeInc;

  assign edgeInc = {strobe.incFetch, strobe.incBuild};

  // index 0 counts build (unbuilt) edges, index 1 counts fetch (built) edges
  for (genvar g = 0; g < NUM_EDGE_CNT; g++) begin : gEdge
    uop_sat_cnt #(.W(CNT_W)) uEdge (
      .clk (clk),
      .rstN(rstN),
      .clr (strobe.clearAll),
      .inc (edgeInc[g]),
      .cnt (edgeCnt[g])
    );
  end

  uop_sat_cnt #(.W(TIMER_W)) uTimer (
    .clk (clk),
    .rstN(rstN),
    .clr (strobe.clearAll),
    .inc (strobe.incTimer),
    .cnt (timerCnt)
  );

  logic [PROD_W-1:0] buildScaled, fetchScaled;
  logic [SUM_W-1:0]  edgeTotal;
  logic              enoughEdges, fetchRatioMet, buildRatioMet, timerExpired;

  always_comb begin
    buildScaled   = PROD_W'(cfgFetchRatio)  * PROD_W'(edgeCnt[0]);
    fetchScaled   = PROD_W'(cfgFilterRatio) * PROD_W'(edgeCnt[1]);
    fetchRatioMet = PROD_W'(edgeCnt[1]) >= buildScaled;
    buildRatioMet = PROD_W'(edgeCnt[0]) >= fetchScaled;
    edgeTotal     = SUM_W'(edgeCnt[0]) + SUM_W'(edgeCnt[1]);
    enoughEdges   = edgeTotal >= SUM_W'(MIN_EDGES);
    timerExpired  = timerCnt >= cfgTimerLimit;
    flags.fetchReady  = fetchRatioMet && enoughEdges && !timerExpired;
    flags.filterReady = buildRatioMet && enoughEdges;
    flags.timeout     = timerExpired;
  end
endmodule

// File: rtl/uop_mode_fsm.sv
module uop_mode_fsm
  import uop_mode_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic             lkBuilt,
  input  logic             lkQualified,
  input  logic             lkMispredict,
  input  logic             tagValid,
  input  logic             tagHit,
  input  logic [IDX_W-1:0] tagIdx,
  input  cntFlags_t        flags,
  output cntStrobe_t       strobe,
  output uopMode_e         modeQ,
  output logic             icacheEn,
  output logic             decodeEn,
  output logic             mainBpEn,
  output logic             allocReq,
  output logic             builtWrEn
);
  uopMode_e modeD;
  logic     mispSeen;
  logic     modeChange;
  logic     edgeCounting;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_FILTER: if (lkValid && lkQualified) modeD = MODE_BUILD;
      MODE_BUILD: begin
        if (flags.fetchReady)   modeD = MODE_FETCH;
        else if (flags.timeout) modeD = MODE_FILTER;
      end
      MODE_FETCH: if (flags.filterReady) modeD = MODE_FILTER;
      default: modeD = MODE_FILTER;
    endcase
  end

  assign modeChange   = (modeD != modeQ);
  assign edgeCounting = (modeQ == MODE_BUILD) || (modeQ == MODE_FETCH);

  always_comb begin
    strobe.clearAll = modeChange;
    strobe.incBuild = lkValid && !lkBuilt && edgeCounting;
    strobe.incFetch = lkValid &&  lkBuilt && edgeCounting;
    strobe.incTimer = lkValid && (modeQ == MODE_BUILD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_FILTER;
      mispSeen <= 1'b0;
    end else begin
      modeQ <= modeD;
      if (modeChange)                              mispSeen <= 1'b0;
      else if (modeQ == MODE_FETCH && lkMispredict) mispSeen <= 1'b1;
    end
  end

  logic tagSameEntry;
  assign tagSameEntry = tagValid && tagHit && (tagIdx == lkIdx);

  always_comb begin
    icacheEn  = (modeQ != MODE_FETCH);
    decodeEn  = (modeQ != MODE_FETCH);
    mainBpEn  = (modeQ != MODE_FETCH) || mispSeen;
    allocReq  = (modeQ == MODE_BUILD) && lkValid && !lkBuilt && !tagSameEntry;
    builtWrEn = tagValid && tagHit;
  end
endmodule

// File: rtl/uop_mode_ctrl.sv
module uop_mode_ctrl
  import uop_mode_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 8,
  parameter int TIMER_W   = 10,
  parameter int THR_W     = 4,
  parameter int MIN_EDGES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic [IDX_W-1:0]   lkIdx,
  input  logic               lkBuilt,
  input  logic               lkQualified,
  input  logic               lkMispredict,
  input  logic               tagValid,
  input  logic               tagHit,
  input  logic [IDX_W-1:0]   tagIdx,
  input  logic [THR_W-1:0]   cfgFetchRatio,
  input  logic [THR_W-1:0]   cfgFilterRatio,
  input  logic [TIMER_W-1:0] cfgTimerLimit,
  output logic [1:0]         mode,
  output logic               icacheEn,
  output logic               decodeEn,
  output logic               mainBpEn,
  output logic               allocReq,
  output logic [IDX_W-1:0]   allocIdx,
  output logic               builtWrEn,
  output logic [IDX_W-1:0]   builtWrIdx
);
  cntStrobe_t strobe;
  cntFlags_t  flags;
  uopMode_e   modeQ;

  uop_mode_fsm #(.IDX_W(IDX_W)) uFsm (
    .clk         (clk),
    .rstN        (rstN),
    .lkValid     (lkValid),
    .lkIdx       (lkIdx),
    .lkBuilt     (lkBuilt),
    .lkQualified (lkQualified),
    .lkMispredict(lkMispredict),
    .tagValid    (tagValid),
    .tagHit      (tagHit),
    .tagIdx      (tagIdx),
    .flags       (flags),
    .strobe      (strobe),
    .modeQ       (modeQ),
    .icacheEn    (icacheEn),
    .decodeEn    (decodeEn),
    .mainBpEn    (mainBpEn),
    .allocReq    (allocReq),
    .builtWrEn   (builtWrEn)
  );

  uop_mode_cnt #(
    .CNT_W    (CNT_W),
    .TIMER_W  (TIMER_W),
    .THR_W    (THR_W),
    .MIN_EDGES(MIN_EDGES)
  ) uCnt (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgFetchRatio (cfgFetchRatio),
    .cfgFilterRatio(cfgFilterRatio),
    .cfgTimerLimit (cfgTimerLimit),
    .flags         (flags)
  );

  assign mode       = modeQ;
  assign allocIdx   = lkIdx;
  assign builtWrIdx = tagIdx;
endmodule

// File: rtl/uop_mode_chk.sv
module uop_mode_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic             lkBuilt,
  input logic             lkQualified,
  input logic             lkMispredict,
  input logic             tagValid,
  input logic             tagHit,
  input logic [1:0]       mode,
  input logic             icacheEn,
  input logic             decodeEn,
  input logic             mainBpEn,
  input logic             allocReq,
  input logic             builtWrEn,
  input logic [IDX_W-1:0] builtWrIdx,
  input logic [IDX_W-1:0] tagIdx
);
  // R1: only the three defined mode codes appear
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd3);

  // R2: Filter is left only after a qualified lookup
  a_r2_filter_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !(lkValid && lkQualified)) |=> mode == 2'd0);

  // R2, R5: Fetch is never entered straight from Filter
  a_r5_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> mode != 2'd2);

  // R3: allocation only for unbuilt lookups in Build mode
  a_r3_alloc_ctx: assert property (@(posedge clk) disable iff (!rstN)
    allocReq |-> (mode == 2'd1 && lkValid && !lkBuilt));

  // R4: built-flag write only on a tag hit, for that entry
  a_r4_wr_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    builtWrEn |-> (tagValid && tagHit && builtWrIdx == tagIdx));

  // R7: instruction cache and decoders off in Fetch mode
  a_r7_fetch_off: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> (!icacheEn && !decodeEn));

  // R9: misprediction in Fetch re-enables the main predictor next cycle
  a_r9_misp_reenable: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && lkMispredict) |=> (mode != 2'd2 || mainBpEn));
endmodule

bind uop_mode_ctrl uop_mode_chk #(.IDX_W(IDX_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .lkValid     (lkValid),
  .lkBuilt     (lkBuilt),
  .lkQualified (lkQualified),
  .lkMispredict(lkMispredict),
  .tagValid    (tagValid),
  .tagHit      (tagHit),
  .mode        (mode),
  .icacheEn    (icacheEn),
  .decodeEn    (decodeEn),
  .mainBpEn    (mainBpEn),
  .allocReq    (allocReq),
  .builtWrEn   (builtWrEn),
  .builtWrIdx  (builtWrIdx),
  .tagIdx      (tagIdx)
);

// File: tb/tb_uop_mode_ctrl.sv
module tb_uop_mode_ctrl;
  localparam int IDX_W = 6;
  localparam int THR_W = 4;
  localparam int TIMER_W = 10;
  localparam int M_FILTER = 0;
  localparam int M_BUILD = 1;
  localparam int M_FETCH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0, lkBuilt = 0, lkQualified = 0, lkMispredict = 0;
  logic [IDX_W-1:0] lkIdx = '0, tagIdx = '0;
  logic tagValid = 0, tagHit = 0;
  logic [THR_W-1:0] cfgFetchRatio = 4'd2, cfgFilterRatio = 4'd15;
  logic [TIMER_W-1:0] cfgTimerLimit = 10'd100;
  logic [1:0] mode;
  logic icacheEn, decodeEn, mainBpEn, allocReq, builtWrEn;
  logic [IDX_W-1:0] allocIdx, builtWrIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int sAlloc, sAllocIdx, sWr, sWrIdx;

  always #4 clk = ~clk;

  uop_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkIdx(lkIdx), .lkBuilt(lkBuilt),
    .lkQualified(lkQualified), .lkMispredict(lkMispredict), .tagValid(tagValid),
    .tagHit(tagHit), .tagIdx(tagIdx), .cfgFetchRatio(cfgFetchRatio),
    .cfgFilterRatio(cfgFilterRatio), .cfgTimerLimit(cfgTimerLimit), .mode(mode),
    .icacheEn(icacheEn), .decodeEn(decodeEn), .mainBpEn(mainBpEn),
    .allocReq(allocReq), .allocIdx(allocIdx), .builtWrEn(builtWrEn),
    .builtWrIdx(builtWrIdx)
  );

  // ratio, timer limit, unbuilt lookups, built lookups, expected mode
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{2, 100, 1, 3, M_FETCH},   // ratio met with 4 edges
    '{3, 100, 1, 2, M_BUILD},   // ratio short
    '{2,   5, 3, 3, M_FILTER},  // timeout first
    '{1,   4, 0, 4, M_FILTER},  // timer equals limit
    '{1,   5, 0, 4, M_FETCH},   // timer one below limit
    '{2, 100, 2, 4, M_FETCH},   // ratio met exactly
    '{2, 100, 2, 3, M_BUILD}    // one edge short of ratio
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit valid, bit built, bit qual, bit misp, int idx,
                       bit tv, bit th, int tidx);
    lkValid = valid; lkBuilt = built; lkQualified = qual; lkMispredict = misp;
    lkIdx = IDX_W'(idx); tagValid = tv; tagHit = th; tagIdx = IDX_W'(tidx);
    @(negedge clk);
    sAlloc = int'(allocReq); sAllocIdx = int'(allocIdx);
    sWr = int'(builtWrEn); sWrIdx = int'(builtWrIdx);
    @(posedge clk); #1;
    lkValid = 0; lkBuilt = 0; lkQualified = 0; lkMispredict = 0;
    tagValid = 0; tagHit = 0;
  endtask

  task automatic look(bit built, int n);
    for (int i = 0; i < n; i++) drive(1, built, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 0;
    idle(3);
    rstN = 1;
    idle(1);
  endtask

  task automatic enterBuild();
    drive(1, 0, 1, 0, 0, 0, 0, 0);
    check("R2 enter build", int'(mode), M_BUILD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 mode", int'(mode), M_FILTER);
    check("R1 icacheEn", int'(icacheEn), 1);
    check("R1 decodeEn", int'(decodeEn), 1);
    check("R1 mainBpEn", int'(mainBpEn), 1);
    check("R1 allocReq", int'(allocReq), 0);

    // R5 R6 table
    for (int v = 0; v < NV; v++) begin
      doReset();
      cfgFetchRatio = THR_W'(VEC[v][0]);
      cfgTimerLimit = TIMER_W'(VEC[v][1]);
      cfgFilterRatio = 4'd15;
      enterBuild();
      look(0, VEC[v][2]);
      look(1, VEC[v][3]);
      idle(2);
      check($sformatf("R5/R6 vector %0d mode", v), int'(mode), VEC[v][4]);
    end

    // R2 unqualified lookup, R3 no alloc in Filter
    doReset();
    drive(1, 0, 0, 0, 3, 0, 0, 0);
    check("R3 no alloc in filter", sAlloc, 0);
    check("R2 unqualified stays filter", int'(mode), M_FILTER);

    // R3 R4 allocation and squash in Build
    cfgFetchRatio = 4'd15; cfgTimerLimit = 10'd100;
    enterBuild();
    drive(1, 0, 0, 0, 5, 0, 0, 0);
    check("R3 alloc unbuilt", sAlloc, 1);
    check("R3 alloc idx", sAllocIdx, 5);
    drive(1, 1, 0, 0, 6, 0, 0, 0);
    check("R3 no alloc built", sAlloc, 0);
    drive(1, 0, 0, 0, 9, 1, 1, 9);
    check("R4 squash same idx", sAlloc, 0);
    check("R4 write enable", sWr, 1);
    check("R4 write idx", sWrIdx, 9);
    drive(1, 0, 0, 0, 11, 1, 1, 7);
    check("R4 other idx not squashed", sAlloc, 1);
    check("R4 write idx other", sWrIdx, 7);
    drive(0, 0, 0, 0, 0, 1, 0, 4);
    check("R4 no write on miss", sWr, 0);

    // R7 R8 R9 Fetch mode
    doReset();
    cfgFetchRatio = 4'd1; cfgFilterRatio = 4'd2; cfgTimerLimit = 10'd100;
    enterBuild();
    look(1, 4);
    idle(2);
    check("R5 reach fetch", int'(mode), M_FETCH);
    check("R7 icacheEn", int'(icacheEn), 0);
    check("R7 decodeEn", int'(decodeEn), 0);
    check("R7 mainBpEn", int'(mainBpEn), 0);
    drive(1, 0, 0, 0, 2, 0, 0, 0);
    check("R3 no alloc in fetch", sAlloc, 0);
    drive(0, 0, 0, 1, 0, 0, 0, 0);
    check("R9 mainBpEn after misp", int'(mainBpEn), 1);
    check("R9 icache still off", int'(icacheEn), 0);
    look(0, 2);
    idle(2);
    check("R8 below min edges stays fetch", int'(mode), M_FETCH);
    look(1, 1);
    idle(2);
    check("R8 return to filter", int'(mode), M_FILTER);
    check("R8 icache back on", int'(icacheEn), 1);

    // R10 saturation
    doReset();
    cfgFetchRatio = 4'd1; cfgFilterRatio = 4'd15; cfgTimerLimit = 10'd1023;
    enterBuild();
    look(0, 300);
    look(1, 100);
    idle(2);
    check("R10 saturated build count holds", int'(mode), M_BUILD);
    look(1, 160);
    idle(2);
    check("R10 fetch after 255 built", int'(mode), M_FETCH);

    // R11 counters cleared across mode changes
    doReset();
    cfgFetchRatio = 4'd1; cfgTimerLimit = 10'd5;
    enterBuild();
    look(0, 5);
    idle(2);
    check("R6 timeout to filter", int'(mode), M_FILTER);
    enterBuild();
    look(1, 4);
    idle(2);
    check("R11 timer cleared on reentry", int'(mode), M_FETCH);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule